// File: doc/BRIEF.md
# Paravirtual Device Legacy Register Window

This block implements the common register area of a legacy paravirtual device exposed through an I/O window. A host access names a byte offset within the window, a direction and an access size. Offsets inside the common area reach the block's own registers. These registers cover the feature masks, the queue selector, the queue base address and size, a notify doorbell, the device status byte, the interrupt status byte and, when message-signalled interrupts are on, two vector registers. Any offset at or above the end of the common area is passed to the device-specific configuration port, with the offset rebased to zero.

Read data is returned combinationally in the same cycle as the access. Write effects and read side effects take hold at the next rising clock edge. Several accesses have side effects. Reading the interrupt status clears it. A status write of zero, or a frame-number write of zero, performs a device reset. A notify write sends a one-cycle doorbell pulse to the queue engine.

Top module: `pv_legacy_regs`

## Requirements
- R1: A read at offset 0 returns DEV_FEAT ORed with the transport feature bits 24, 28 and 30 (0x5100_0021 with default parameters). Writes to offset 0 have no effect.
- R2: A write at offset 4 stores the value as the driver feature mask, and a read at offset 4 returns it. If bit 30 of the written value is set, FALLBACK_FEAT (default 0) is stored instead.
- R3: A write at offset 8 stores the value shifted left by 12 as the base address of the selected queue, which is shown on sel_qaddr. A read at offset 8 returns that address shifted right by 12.
- R4: A write at offset 14 changes the queue selector only when the value is below NUM_Q. Otherwise the selector and sel_qaddr stay unchanged. A read at offset 12 returns QSIZE.
- R5: A write at offset 16 with a value below NUM_Q raises notify_valid for exactly one cycle after the access, with notify_q carrying that value. No register changes on this write.
- R6: A write at offset 18 stores the status byte. Writing status 0, or writing 0 at offset 8, resets the device: the selector, all queue addresses, the status and the feature mask return to 0, and all vectors return to 0xFFFF. dev_reset pulses for one cycle after such an access.
- R7: Bits of isr_set are ORed into the interrupt status. A read at offset 19 returns the status and clears it. Bits set in the same cycle as the read are kept.
- R8: irq follows bit 0 of the interrupt status while msix_en is 0, and is held at 0 while msix_en is 1.
- R9: A read of an unmapped offset within the common area (for example 2 or 16) returns 0xFFFF_FFFF. A write to such an offset has no effect.
- R10: While msix_en is 1, offset 20 holds the configuration vector and offset 22 holds the vector of the selected queue. A written value of NUM_VEC or above is stored as 0xFFFF.
- R11: Accesses at or above offset 20 (msix_en=0) or offset 24 (msix_en=1) assert dcfg_valid, with dcfg_off equal to the offset minus that boundary. A read of such an offset returns dcfg_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msix_en | input | 1 | Message-signalled interrupts enabled |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access size (0 byte, 1 halfword, 2 word) |
| acc_off | input | 8 | Byte offset in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the access cycle |
| isr_set | input | 8 | Interrupt status bits raised by the device |
| irq | output | 1 | Level interrupt |
| notify_valid | output | 1 | Doorbell pulse |
| notify_q | output | QW | Queue index of the doorbell |
| dev_reset | output | 1 | Device reset pulse |
| sel_qaddr | output | 44 | Base address of the selected queue |
| dcfg_valid | output | 1 | Device-config access strobe |
| dcfg_write | output | 1 | Device-config write |
| dcfg_size | output | 2 | Device-config access size |
| dcfg_off | output | 8 | Rebased device-config offset |
| dcfg_wdata | output | 32 | Device-config write data |
| dcfg_rdata | input | 32 | Device-config read data |

## Verification
The assertions check four behaviours on every cycle. They cover the forwarding boundary and its rebasing, the all-ones value of unmapped reads, the irq drop after an interrupt-status read, and the one-cycle doorbell and reset pulses. They also check that an out-of-range selector write leaves the selected queue address stable. Only the bench scenarios can show how values flow across several accesses. These include feature fallback, frame-number round trips on different queues, vector allocation failures, and full state recovery after both kinds of device reset.

// File: rtl/pv_legacy_regs.sv
module pv_legacy_regs #(
  parameter int          NUM_Q         = 4,
  parameter int          NUM_VEC       = 4,
  parameter logic [15:0] QSIZE         = 16'd256,
  parameter logic [31:0] DEV_FEAT      = 32'h0000_0021,
  parameter logic [31:0] FALLBACK_FEAT = 32'h0,
  localparam int         QW            = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int         AW            = 44
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          msix_en,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [1:0]    acc_size,
  input  logic [7:0]    acc_off,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [7:0]    isr_set,
  output logic          irq,
  output logic          notify_valid,
  output logic [QW-1:0] notify_q,
  output logic          dev_reset,
  output logic [AW-1:0] sel_qaddr,
  output logic          dcfg_valid,
  output logic          dcfg_write,
  output logic [1:0]    dcfg_size,
  output logic [7:0]    dcfg_off,
  output logic [31:0]   dcfg_wdata,
  input  logic [31:0]   dcfg_rdata
);
  localparam logic [31:0] HOSTF = DEV_FEAT | (32'h1 << 24) | (32'h1 << 28) | (32'h1 << 30);
  localparam logic [15:0] NOVEC = 16'hFFFF;

  logic [31:0]   gfeat;
  logic [QW-1:0] qsel;
  logic [AW-1:0] qaddr [NUM_Q];
  logic [15:0]   qvec  [NUM_Q];
  logic [15:0]   cvec;
  logic [7:0]    status, isr, isr_nx;

  wire [7:0] base      = msix_en ? 8'd24 : 8'd20;
  wire       in_common = acc_off < base;
  wire       wr        = acc_valid && acc_write && in_common;
  wire       rd        = acc_valid && !acc_write && in_common;
  wire       w16_ok_q  = wdata[15:0] < 16'(NUM_Q);
  wire       w16_ok_v  = wdata[15:0] < 16'(NUM_VEC);
  wire       do_reset  = wr && ((acc_off == 8'd18 && wdata[7:0] == 8'd0) ||
                                (acc_off == 8'd8 && wdata == 32'd0));

  assign sel_qaddr  = qaddr[qsel];
  assign dcfg_valid = acc_valid && !in_common;
  assign dcfg_write = acc_write;
  assign dcfg_size  = acc_size;
  assign dcfg_off   = acc_off - base;
  assign dcfg_wdata = wdata;

  always_comb begin
    rdata = 32'hFFFF_FFFF;
    if (acc_valid && !in_common) rdata = dcfg_rdata;
    else if (acc_valid) begin
      case (acc_off)
        8'd0:    rdata = HOSTF;
        8'd4:    rdata = gfeat;
        8'd8:    rdata = sel_qaddr[AW-1:12];
        8'd12:   rdata = {16'd0, QSIZE};
        8'd14:   rdata = 32'(qsel);
        8'd18:   rdata = {24'd0, status};
        8'd19:   rdata = {24'd0, isr};
        8'd20:   rdata = {16'd0, cvec};
        8'd22:   rdata = {16'd0, qvec[qsel]};
        default: rdata = 32'hFFFF_FFFF;
      endcase
    end
  end

  assign isr_nx = ((rd && acc_off == 8'd19) ? 8'd0 : isr) | isr_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr <= 8'd0;
      irq <= 1'b0;
    end else begin
      isr <= isr_nx;
      irq <= !msix_en && isr_nx[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      notify_valid <= 1'b0;
      notify_q     <= '0;
      dev_reset    <= 1'b0;
    end else begin
      notify_valid <= wr && acc_off == 8'd16 && w16_ok_q;
      notify_q     <= wdata[QW-1:0];
      dev_reset    <= do_reset;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || do_reset) begin
      gfeat  <= 32'd0;
      qsel   <= '0;
      status <= 8'd0;
      cvec   <= NOVEC;
      for (int i = 0; i < NUM_Q; i++) begin
        qaddr[i] <= '0;
        qvec[i]  <= NOVEC;
      end
    end else if (wr) begin
      case (acc_off)
        8'd4:  gfeat <= wdata[30] ? FALLBACK_FEAT : wdata;
        8'd8:  qaddr[qsel] <= {wdata, 12'd0};
        8'd14: if (w16_ok_q) qsel <= wdata[QW-1:0];
        8'd18: status <= wdata[7:0];
        8'd20: cvec <= w16_ok_v ? wdata[15:0] : NOVEC;
        8'd22: qvec[qsel] <= w16_ok_v ? wdata[15:0] : NOVEC;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pv_legacy_regs_chk.sv
module pv_legacy_regs_chk #(
  parameter int NUM_Q = 4,
  parameter int QW    = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          msix_en,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [7:0]    acc_off,
  input logic [31:0]   wdata,
  input logic [31:0]   rdata,
  input logic [7:0]    isr_set,
  input logic          irq,
  input logic          notify_valid,
  input logic          dev_reset,
  input logic [43:0]   sel_qaddr,
  input logic          dcfg_valid,
  input logic [7:0]    dcfg_off
);
  a_r11_fwd_nomsix: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !msix_en && acc_off >= 8'd20) |-> (dcfg_valid && dcfg_off == acc_off - 8'd20));

  a_r11_fwd_msix: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && msix_en && acc_off >= 8'd24) |-> (dcfg_valid && dcfg_off == acc_off - 8'd24));

  a_r9_unmapped_ones: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && (acc_off == 8'd2 || acc_off == 8'd16)) |-> rdata == 32'hFFFF_FFFF);

  a_r7_isr_read_drops_irq: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && acc_off == 8'd19 && isr_set == 8'd0) |=> !irq);

  a_r8_irq_off_with_msix: assert property (@(posedge clk) disable iff (rst)
    msix_en |=> (!irq || !$past(msix_en)));

  a_r5_notify_cause: assert property (@(posedge clk) disable iff (rst)
    notify_valid |-> $past(acc_valid && acc_write && acc_off == 8'd16 && wdata[15:0] < 16'(NUM_Q)));

  a_r6_reset_cause: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_off == 8'd18 && wdata[7:0] == 8'd0) |=> dev_reset);

  a_r4_bad_sel_stable: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_off == 8'd14 && wdata[15:0] >= 16'(NUM_Q)) |=> $stable(sel_qaddr));
endmodule

bind pv_legacy_regs pv_legacy_regs_chk #(.NUM_Q(NUM_Q), .QW(QW)) u_chk (
  .clk(clk), .rst(rst), .msix_en(msix_en), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_off(acc_off), .wdata(wdata), .rdata(rdata), .isr_set(isr_set), .irq(irq),
  .notify_valid(notify_valid), .dev_reset(dev_reset), .sel_qaddr(sel_qaddr),
  .dcfg_valid(dcfg_valid), .dcfg_off(dcfg_off)
);

// File: tb/tb_pv_legacy_regs.sv
module tb_pv_legacy_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HOSTF = 32'h5100_0021;
  localparam logic [31:0] DCR   = 32'hC0DE_0042;

  logic clk = 0, rst = 1, msix_en = 0, acc_valid = 0, acc_write = 0;
  logic [1:0] acc_size = 2'd2;
  logic [7:0] acc_off = 0, isr_set = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, notify_valid, dev_reset, dcfg_valid, dcfg_write;
  logic [1:0] notify_q, dcfg_size;
  logic [43:0] sel_qaddr;
  logic [7:0] dcfg_off;
  logic [31:0] dcfg_wdata;

  int errs = 0, checks = 0;
  logic [31:0] rv;
  logic [7:0] dco;
  logic dcv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pv_legacy_regs dut (
    .clk(clk), .rst(rst), .msix_en(msix_en), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_off(acc_off), .wdata(wdata), .rdata(rdata), .isr_set(isr_set),
    .irq(irq), .notify_valid(notify_valid), .notify_q(notify_q), .dev_reset(dev_reset),
    .sel_qaddr(sel_qaddr), .dcfg_valid(dcfg_valid), .dcfg_write(dcfg_write),
    .dcfg_size(dcfg_size), .dcfg_off(dcfg_off), .dcfg_wdata(dcfg_wdata), .dcfg_rdata(DCR)
  );

  // {is_write, offset, data, expected}
  localparam int NV = 18;
  localparam logic [72:0] TBL [NV] = '{
    {1'b0, 8'd0,  32'h0,         HOSTF},          // R1
    {1'b1, 8'd0,  32'h1,         32'h0},          // R1 write ignored
    {1'b0, 8'd0,  32'h0,         HOSTF},          // R1
    {1'b1, 8'd4,  32'h0000_00A5, 32'h0},
    {1'b0, 8'd4,  32'h0,         32'h0000_00A5},  // R2
    {1'b1, 8'd4,  32'h4000_0001, 32'h0},
    {1'b0, 8'd4,  32'h0,         32'h0},          // R2 fallback
    {1'b1, 8'd14, 32'h1,         32'h0},
    {1'b1, 8'd8,  32'h0001_2345, 32'h0},
    {1'b0, 8'd8,  32'h0,         32'h0001_2345},  // R3
    {1'b1, 8'd14, 32'h9,         32'h0},
    {1'b0, 8'd14, 32'h0,         32'h1},          // R4 selector kept
    {1'b0, 8'd12, 32'h0,         32'd256},        // R4 size
    {1'b1, 8'd18, 32'h7,         32'h0},
    {1'b0, 8'd18, 32'h0,         32'h7},          // R6 status
    {1'b1, 8'd2,  32'hFFFF,      32'h0},
    {1'b0, 8'd2,  32'h0,         32'hFFFF_FFFF},  // R9
    {1'b0, 8'd16, 32'h0,         32'hFFFF_FFFF}   // R9
  };

  task automatic chk(input string req, input logic [43:0] got, input logic [43:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_off = off; wdata = d;
    #1 rv = rdata; dco = dcfg_off; dcv = dcfg_valid;
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic pulse_isr(input logic [7:0] v);
    @(negedge clk); isr_set = v;
    @(posedge clk); #1 isr_set = 0;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk("R8 reset irq", irq, 0);
    chk("R6 reset pulse idle", dev_reset, 0);
    acc(0, 8'd18, 0); chk("R6 reset status", rv, 0);

    for (int i = 0; i < NV; i++) begin
      acc(TBL[i][72], TBL[i][71:64], TBL[i][63:32]);
      if (!TBL[i][72]) chk($sformatf("table[%0d] R1-R9 vector", i), rv, TBL[i][31:0]);
    end

    // R3 sel_qaddr and per-queue storage
    chk("R3 sel_qaddr", sel_qaddr, 44'h0001_2345_000);
    acc(1, 8'd14, 2); chk("R3 other queue empty", sel_qaddr, 0);
    acc(1, 8'd8, 32'h00AB_CDEF); acc(0, 8'd8, 0); chk("R3 queue2 pfn", rv, 32'h00AB_CDEF);
    acc(1, 8'd14, 1); chk("R3 queue1 kept", sel_qaddr, 44'h0001_2345_000);

    // R5 notify
    acc(1, 8'd16, 3);
    chk("R5 pulse", notify_valid, 1); chk("R5 index", notify_q, 3);
    @(posedge clk); #1 chk("R5 single cycle", notify_valid, 0);
    acc(1, 8'd14, 0); acc(0, 8'd14, 0); chk("R5 no state change", rv, 0);
    acc(1, 8'd16, 5); chk("R5 bad index no pulse", notify_valid, 0);

    // R7 / R8 interrupt status
    pulse_isr(8'h03); chk("R8 irq follows bit0", irq, 1);
    acc(0, 8'd19, 0); chk("R7 isr read", rv, 32'h3); chk("R7 irq dropped", irq, 0);
    acc(0, 8'd19, 0); chk("R7 isr cleared", rv, 0);
    pulse_isr(8'h02); chk("R8 bit1 no irq", irq, 0);
    acc(0, 8'd19, 0); chk("R7 bit1 read", rv, 32'h2);
    msix_en = 1;
    pulse_isr(8'h01); chk("R8 irq off under msix", irq, 0);
    acc(0, 8'd19, 0); chk("R7 isr under msix", rv, 32'h1);

    // R10 vectors
    acc(0, 8'd20, 0); chk("R10 cfg vec reset", rv, 32'hFFFF);
    acc(1, 8'd20, 2); acc(0, 8'd20, 0); chk("R10 cfg vec", rv, 2);
    acc(1, 8'd20, 9); acc(0, 8'd20, 0); chk("R10 cfg vec fail", rv, 32'hFFFF);
    acc(1, 8'd14, 1); acc(1, 8'd22, 3); acc(0, 8'd22, 0); chk("R10 q1 vec", rv, 3);
    acc(1, 8'd14, 0); acc(0, 8'd22, 0); chk("R10 q0 vec", rv, 32'hFFFF);

    // R11 forwarding
    acc(0, 8'd24, 0);
    chk("R11 msix fwd data", rv, DCR); chk("R11 msix fwd off", dco, 0); chk("R11 fwd valid", dcv, 1);
    acc(0, 8'd22, 0); chk("R11 not fwd under msix", dcv, 0);
    msix_en = 0;
    acc(0, 8'd22, 0);
    chk("R11 fwd data", rv, DCR); chk("R11 fwd off", dco, 2);
    acc(1, 8'd20, 1); chk("R11 fwd write", dcv, 1);

    // R6 device reset via status 0
    acc(1, 8'd14, 2); acc(1, 8'd4, 32'h11);
    acc(1, 8'd18, 0); chk("R6 status0 pulse", dev_reset, 1);
    @(posedge clk); #1 chk("R6 pulse single", dev_reset, 0);
    acc(0, 8'd14, 0); chk("R6 sel cleared", rv, 0);
    acc(1, 8'd14, 2); acc(0, 8'd8, 0); chk("R6 pfn cleared", rv, 0);
    acc(0, 8'd4, 0); chk("R6 features cleared", rv, 0);

    // R6 device reset via pfn 0
    msix_en = 1;
    acc(1, 8'd20, 1); acc(1, 8'd18, 8'h0F);
    acc(1, 8'd8, 0); chk("R6 pfn0 pulse", dev_reset, 1);
    acc(0, 8'd18, 0); chk("R6 pfn0 status", rv, 0);
    acc(0, 8'd20, 0); chk("R6 vectors released", rv, 32'hFFFF);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule